// File: doc/BRIEF.md
# Split-Word Writeback Scheduler

This block follows issued instructions down a ten-stage execute pipeline and raises register-file write strobes in the stage that each instruction class dictates. The result (up to 64 bits) and the destination register pair are captured at issue and travel with the instruction. A 64-bit result is committed as two 32-bit writes in different cycles: the lower half to the even register of the pair, the upper half to the odd register. No arithmetic is done here, and the register file itself lies outside the block.

A global `advance` input moves the whole pipeline one stage per clock. While it is low every in-flight instruction holds its stage and no strobe is raised. An instruction whose condition flag is false occupies stage 1 only and then leaves the pipeline without writing anything. Two write ports are provided because writes from different in-flight instructions can fall in the same cycle.

Top module: `wb_sched`

## Requirements
- R1: After reset, with nothing issued, both write enables stay low.
- R2: Class code 0 (load) with a true condition makes one write of `issue_data[31:0]` to address {pair,0} in stage 5. An instruction is in stage k during the cycle after the k-th advancing clock edge, the issuing edge counted as the first.
- R3: Class code 1 (conversion or single-to-double multiply) writes the lower half to {pair,0} in stage 4 and the upper half `issue_data[63:32]` to {pair,1} in stage 5.
- R4: Class code 2 (double add/subtract, mixed single/double multiply) writes the lower half to {pair,0} in stage 6 and the upper half to {pair,1} in stage 7.
- R5: Class code 3 (32-bit integer multiply) makes one write of `issue_data[31:0]` to {pair,0} in stage 9.
- R6: Class code 4 (double multiply, mixed integer/double multiply) writes the lower half to {pair,0} in stage 9 and the upper half to {pair,1} in stage 10.
- R7: An instruction issued with `issue_cond` low produces no write in any stage.
- R8: While `advance` is low, both write enables are low, every in-flight instruction keeps its stage, and an issue request in that cycle is ignored.
- R9: In each cycle the writes requested are placed oldest first (highest stage first): the first on port 0 and the second on port 1. Port 1 is enabled only when port 0 is. Requests beyond two in one cycle are dropped.
- R10: Class codes 5, 6 and 7 produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Pipeline advance; low means stall |
| issue_valid | input | 1 | An instruction enters stage 1 at this edge |
| issue_cls | input | 3 | Instruction class code |
| issue_pair | input | PAIR_W | Destination register-pair index |
| issue_cond | input | 1 | Condition evaluated true |
| issue_data | input | 2*HALF_W | Result carried to writeback |
| wr0_en | output | 1 | Port 0 write enable |
| wr0_addr | output | PAIR_W+1 | Port 0 register address {pair, half} |
| wr0_data | output | HALF_W | Port 0 write data |
| wr1_en | output | 1 | Port 1 write enable |
| wr1_addr | output | PAIR_W+1 | Port 1 register address {pair, half} |
| wr1_data | output | HALF_W | Port 1 write data |

## Verification
Writeback from an older instruction and writeback from a younger one land in the same cycle when their issue gap equals the difference between their commit stages. For example, a class 2 upper half in stage 7 meets a class 1 lower half in stage 4 when the second is issued three cycles later. The bench provokes this by sweeping every ordered pair of writing classes over issue gaps of zero to six cycles. Each cycle it compares both ports against a model that places requests oldest first. It also reports as a failure any cycle in which both ports hit one address.

// File: rtl/wb_sched.sv
module wb_sched #(
  parameter int PAIR_W = 4,
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  advance,
  input  logic                  issue_valid,
  input  logic [2:0]            issue_cls,
  input  logic [PAIR_W-1:0]     issue_pair,
  input  logic                  issue_cond,
  input  logic [2*HALF_W-1:0]   issue_data,
  output logic                  wr0_en,
  output logic [PAIR_W:0]       wr0_addr,
  output logic [HALF_W-1:0]     wr0_data,
  output logic                  wr1_en,
  output logic [PAIR_W:0]       wr1_addr,
  output logic [HALF_W-1:0]     wr1_data
);
  localparam int NSTG = 10;
  localparam int NSLOT = 6;
  localparam int SLOT_STG [NSLOT] = '{10, 9, 7, 6, 5, 4};

  logic [NSTG:1]         v;
  logic                  cond1;
  logic [2:0]            cls_q  [1:NSTG];
  logic [PAIR_W-1:0]     pair_q [1:NSTG];
  logic [2*HALF_W-1:0]   dat_q  [1:NSTG];

  // returns {write requested, upper half}
  function automatic logic [1:0] wb_kind(input int stg, input logic [2:0] c);
    case (stg)
      4:  wb_kind = (c == 3'd1) ? 2'b10 : 2'b00;
      5:  wb_kind = (c == 3'd0) ? 2'b10 : (c == 3'd1) ? 2'b11 : 2'b00;
      6:  wb_kind = (c == 3'd2) ? 2'b10 : 2'b00;
      7:  wb_kind = (c == 3'd2) ? 2'b11 : 2'b00;
      9:  wb_kind = (c == 3'd3 || c == 3'd4) ? 2'b10 : 2'b00;
      10: wb_kind = (c == 3'd4) ? 2'b11 : 2'b00;
      default: wb_kind = 2'b00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v     <= '0;
      cond1 <= 1'b0;
    end else if (advance) begin
      v[1]  <= issue_valid;
      cond1 <= issue_cond;
      v[2]  <= v[1] & cond1;
      for (int k = 3; k <= NSTG; k++) v[k] <= v[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      cls_q[1]  <= issue_cls;
      pair_q[1] <= issue_pair;
      dat_q[1]  <= issue_data;
      for (int k = 2; k <= NSTG; k++) begin
        cls_q[k]  <= cls_q[k-1];
        pair_q[k] <= pair_q[k-1];
        dat_q[k]  <= dat_q[k-1];
      end
    end
  end

  always_comb begin
    wr0_en = 1'b0; wr0_addr = '0; wr0_data = '0;
    wr1_en = 1'b0; wr1_addr = '0; wr1_data = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (v[SLOT_STG[s]] && advance && wb_kind(SLOT_STG[s], cls_q[SLOT_STG[s]])[1]) begin
        if (!wr0_en) begin
          wr0_en   = 1'b1;
          wr0_addr = {pair_q[SLOT_STG[s]], wb_kind(SLOT_STG[s], cls_q[SLOT_STG[s]])[0]};
          wr0_data = wb_kind(SLOT_STG[s], cls_q[SLOT_STG[s]])[0]
                     ? dat_q[SLOT_STG[s]][2*HALF_W-1:HALF_W] : dat_q[SLOT_STG[s]][HALF_W-1:0];
        end else if (!wr1_en) begin
          wr1_en   = 1'b1;
          wr1_addr = {pair_q[SLOT_STG[s]], wb_kind(SLOT_STG[s], cls_q[SLOT_STG[s]])[0]};
          wr1_data = wb_kind(SLOT_STG[s], cls_q[SLOT_STG[s]])[0]
                     ? dat_q[SLOT_STG[s]][2*HALF_W-1:HALF_W] : dat_q[SLOT_STG[s]][HALF_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/wb_sched_chk.sv
module wb_sched_chk #(
  parameter int PAIR_W = 4,
  parameter int HALF_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  advance,
  input logic                  issue_valid,
  input logic [2:0]            issue_cls,
  input logic [PAIR_W-1:0]     issue_pair,
  input logic                  issue_cond,
  input logic [2*HALF_W-1:0]   issue_data,
  input logic                  wr0_en,
  input logic [PAIR_W:0]       wr0_addr,
  input logic [HALF_W-1:0]     wr0_data,
  input logic                  wr1_en,
  input logic [PAIR_W:0]       wr1_addr,
  input logic [HALF_W-1:0]     wr1_data
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !wr0_en && !wr1_en);

  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |-> !wr0_en && !wr1_en);

  // R9
  port_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> wr0_en);

  // R2
  load_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue_valid && issue_cls == 3'd0 && issue_cond && advance, 5) &&
     $past(advance, 4) && $past(advance, 3) && $past(advance, 2) && $past(advance, 1) && advance)
    |-> (wr0_en && wr0_addr == {$past(issue_pair, 5), 1'b0} && wr0_data == $past(issue_data[HALF_W-1:0], 5)) ||
        (wr1_en && wr1_addr == {$past(issue_pair, 5), 1'b0} && wr1_data == $past(issue_data[HALF_W-1:0], 5)));
endmodule

bind wb_sched wb_sched_chk #(.PAIR_W(PAIR_W), .HALF_W(HALF_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .advance(advance), .issue_valid(issue_valid),
  .issue_cls(issue_cls), .issue_pair(issue_pair), .issue_cond(issue_cond),
  .issue_data(issue_data), .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
  .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data)
);

// File: tb/test_wb_sched.sv
module test_wb_sched;
  localparam int CLK_PERIOD = 10;
  localparam int PAIR_W = 4;
  localparam int HALF_W = 32;
  localparam int NM = 64;

  logic clk = 1'b0, rst_n = 1'b0, advance = 1'b0, issue_valid = 1'b0, issue_cond = 1'b0;
  logic [2:0] issue_cls = '0;
  logic [PAIR_W-1:0] issue_pair = '0;
  logic [2*HALF_W-1:0] issue_data = '0;
  logic wr0_en, wr1_en;
  logic [PAIR_W:0] wr0_addr, wr1_addr;
  logic [HALF_W-1:0] wr0_data, wr1_data;

  int checks = 0, errors = 0, nid = 0;
  string tag = "R1";

  int m_age [NM];
  logic m_live [NM];
  logic [2:0] m_cls [NM];
  logic [PAIR_W-1:0] m_pair [NM];
  logic m_cond [NM];
  logic [2*HALF_W-1:0] m_dat [NM];

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_sched #(.PAIR_W(PAIR_W), .HALF_W(HALF_W)) i_wb_sched (
    .clk(clk), .rst_n(rst_n), .advance(advance), .issue_valid(issue_valid),
    .issue_cls(issue_cls), .issue_pair(issue_pair), .issue_cond(issue_cond),
    .issue_data(issue_data), .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data));

  // write table from R2..R6: returns {req, upper}
  function automatic logic [1:0] spec_kind(input int stg, input logic [2:0] c);
    spec_kind = 2'b00;
    if (c == 3'd0 && stg == 5) spec_kind = 2'b10;
    if (c == 3'd1 && stg == 4) spec_kind = 2'b10;
    if (c == 3'd1 && stg == 5) spec_kind = 2'b11;
    if (c == 3'd2 && stg == 6) spec_kind = 2'b10;
    if (c == 3'd2 && stg == 7) spec_kind = 2'b11;
    if (c == 3'd3 && stg == 9) spec_kind = 2'b10;
    if (c == 3'd4 && stg == 9) spec_kind = 2'b10;
    if (c == 3'd4 && stg == 10) spec_kind = 2'b11;
  endfunction

  task automatic compare();
    logic e0 = 0, e1 = 0;
    logic [PAIR_W:0] a0 = '0, a1 = '0;
    logic [HALF_W-1:0] d0 = '0, d1 = '0;
    logic bad;
    for (int stg = 10; stg >= 1; stg--)
      for (int i = 0; i < NM; i++)
        if (m_live[i] && m_cond[i] && advance && m_age[i] == stg && spec_kind(stg, m_cls[i])[1]) begin
          logic up = spec_kind(stg, m_cls[i])[0];
          logic [HALF_W-1:0] dv = up ? m_dat[i][2*HALF_W-1:HALF_W] : m_dat[i][HALF_W-1:0];
          if (!e0) begin e0 = 1; a0 = {m_pair[i], up}; d0 = dv; end
          else if (!e1) begin e1 = 1; a1 = {m_pair[i], up}; d1 = dv; end
        end
    checks++;
    bad = (wr0_en !== e0) || (wr1_en !== e1) ||
          (e0 && (wr0_addr !== a0 || wr0_data !== d0)) ||
          (e1 && (wr1_addr !== a1 || wr1_data !== d1));
    if (bad) begin
      errors++;
      $display("FAIL %s: got p0 %b/%h/%h p1 %b/%h/%h expected p0 %b/%h/%h p1 %b/%h/%h", tag,
               wr0_en, wr0_addr, wr0_data, wr1_en, wr1_addr, wr1_data, e0, a0, d0, e1, a1, d1);
    end
    if (wr0_en && wr1_en) begin
      checks++;
      if (wr0_addr == wr1_addr) begin
        errors++;
        $display("FAIL %s: collision got addr %h on both ports expected distinct", tag, wr0_addr);
      end
    end
  endtask

  task automatic step(input logic iv, input logic [2:0] c, input logic [PAIR_W-1:0] p,
                      input logic cd, input logic adv);
    logic [2*HALF_W-1:0] dv = {32'h1000_0000 + nid, 32'h2000_0000 + nid};
    issue_valid = iv; issue_cls = c; issue_pair = p; issue_cond = cd; advance = adv; issue_data = dv;
    #1;
    compare();
    @(posedge clk);
    if (adv) begin
      for (int i = 0; i < NM; i++)
        if (m_live[i]) begin
          m_age[i]++;
          if (m_age[i] > 11) m_live[i] = 0;
        end
      if (iv) begin
        m_live[nid % NM] = 1; m_age[nid % NM] = 1; m_cls[nid % NM] = c;
        m_pair[nid % NM] = p; m_cond[nid % NM] = cd; m_dat[nid % NM] = dv;
        nid++;
      end
    end
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 12; i++) step(0, 3'd0, '0, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string ctag [8] = '{"R2", "R3", "R4", "R5", "R6", "R10", "R10", "R10"};
    for (int i = 0; i < NM; i++) m_live[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    for (int i = 0; i < 4; i++) step(0, 3'd0, '0, 0, 1);

    // single issue of every class under both condition values
    for (int c = 0; c < 8; c++)
      for (int cd = 0; cd < 2; cd++) begin
        tag = cd ? ctag[c] : "R7";
        step(1, 3'(c), 4'(c + 3), cd[0], 1);
        drain();
      end

    // overlapping writebacks from two instructions
    tag = "R9";
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int g = 0; g < 7; g++) begin
          step(1, 3'(a), 4'd2, 1, 1);
          for (int i = 0; i < g; i++) step(0, 3'd0, '0, 0, 1);
          step(1, 3'(b), 4'd9, 1, 1);
          drain();
        end

    // stalls interleaved with issues, including heavy overlap
    tag = "R8";
    for (int t = 0; t < 400; t++)
      step((t % 2) == 0, 3'((t / 2) % 6), 4'(t % 16), (t % 7) != 3, ((t * 7) % 5) != 0);
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule